// File: doc/BRIEF.md
# Triggered Command Set Sequencer

This block holds one set of command slots, each carrying a message word, a target address and a data word. Software fills the slots over a simple register bus. It then selects which slots take part and which must wait for a response, and arms the set with a two-step control sequence. Once armed, the engine walks the slots from the lowest index to the highest. It presents each selected command on a valid/ready request port and, where a response is needed, waits for it on a response port before it moves to the next slot.

Each slot has a read-only status word that shows whether its command went out and whether it finished. It also has a read-only word that keeps the data of the last response. When the walk ends, the block sets a one-bit done flag. That flag drives the interrupt pin only while its enable bit is set, and software clears it by writing a one to a separate clear address. The engine stays busy after it finishes, until software drops the trigger bit. While the engine is busy, the slot contents and the selection masks cannot be changed.

Register offsets, in bytes: 0x00 interrupt enable (bit 0), 0x04 interrupt status (bit 0, read-only), 0x08 interrupt clear (bit 0, write-only, reads zero), 0x10 wait mask, 0x14 control (enable bit 16, trigger bit 24), 0x18 idle flag (bit 0), 0x1C slot-select mask. Slot k occupies 0x30 + 20·k, and its words sit at these offsets: +0 message, +4 address, +8 data, +12 status, +16 response. In the message word, bit 8 asks for a response and bit 16 marks a write. In the status word, bit 8 means issued and bit 16 means completed.

Top module: `trig_cmd_seq`

## Requirements
- R1: After reset every register reads zero except the idle flag (offset 0x18 bit 0), which reads one; the request valid and the interrupt pin are low.
- R2: A transfer starts only on a control write that sets both bit 16 and bit 24 while the stored control value has bit 16 set and bit 24 clear; setting both bits at once from zero starts nothing.
- R3: The engine presents only the slots whose bit is set in the select mask, in ascending slot order, with the slot's address and data, and with the write flag copied from message bit 16; a request is held stable until it is accepted.
- R4: A slot needs a response when its wait-mask bit or its message bit 8 is set; the response flag shows this, no further request is presented until the response arrives, and the response data is stored in that slot's response word.
- R5: The status word of every selected slot reads bit 8 (issued) and bit 16 (completed) set after the transfer; unselected slots read zero; all status bits clear when a transfer starts.
- R6: The idle flag reads zero from the start of a transfer until the trigger bit has been cleared after completion, and reads one again afterwards.
- R7: When the walk completes, interrupt status bit 0 is set; the interrupt pin follows status AND enable.
- R8: Writing a one to bit 0 at the clear offset clears the interrupt status and drops the pin; the clear offset reads zero.
- R9: Writes to the slot words, the select mask and the wait mask are ignored while the engine is busy.
- R10: A transfer with an empty select mask issues no request and still raises the done status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data (combinational from bus_addr) |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Command request accepted |
| req_addr | output | DW | Target address of the current command |
| req_data | output | DW | Data of the current command |
| req_write | output | 1 | Current command is a write |
| req_resp | output | 1 | Current command expects a response |
| rsp_valid | input | 1 | Response arrives |
| rsp_data | input | DW | Response data |
| irq | output | 1 | Done interrupt, gated by the enable bit |

## Verification
The bench targets the edges of the slot walk. It selects only the first and the last slot, all slots, and none, so a scan that stops early or wraps around either misses the last slot or never raises done. It stalls request acceptance and responses for random spans, which catches a design that moves on before a response, or one that lets the request address change while it is held. It writes new slot and mask values during a busy transfer and reads them back afterwards, so a missing lock shows up as corrupted contents. It also writes enable and trigger together from zero, which exposes a start condition that ignores the arming order.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

    // register byte offsets
    localparam int OFF_IRQ_EN   = 'h00;
    localparam int OFF_IRQ_STAT = 'h04;
    localparam int OFF_IRQ_CLR  = 'h08;
    localparam int OFF_WAIT     = 'h10;
    localparam int OFF_CTRL     = 'h14;
    localparam int OFF_IDLE     = 'h18;
    localparam int OFF_SEL      = 'h1C;

    // slot window
    localparam int SLOT_BASE    = 'h30;
    localparam int SLOT_STRIDE  = 20;
    localparam int SLOT_MSG     = 0;
    localparam int SLOT_ADR     = 4;
    localparam int SLOT_DAT     = 8;
    localparam int SLOT_STS     = 12;
    localparam int SLOT_RSP     = 16;

    // bit positions
    localparam int CTRL_EN_BIT   = 16;
    localparam int CTRL_TRIG_BIT = 24;
    localparam int MSG_RESP_BIT  = 8;
    localparam int MSG_WR_BIT    = 16;
    localparam int STS_ISS_BIT   = 8;
    localparam int STS_CMP_BIT   = 16;

    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_SCAN = 3'd1,
        ENG_REQ  = 3'd2,
        ENG_RSP  = 3'd3,
        ENG_HOLD = 3'd4
    } eng_state_e;

endpackage

// File: rtl/tcq_irq.sv
module tcq_irq
    import tcq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic          wbit,
    input  logic          done,
    output logic          en_q,
    output logic          stat_q,
    output logic          irq
);

    typedef struct packed {
        logic en;
        logic stat;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d = q;
        if (bus_we && bus_addr == AW'(OFF_IRQ_EN)) begin
            d.en = wbit;
        end
        if (bus_we && bus_addr == AW'(OFF_IRQ_CLR) && wbit) begin
            d.stat = 1'b0;
        end
        // a completion in the same cycle as a clear wins
        if (done) begin
            d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_q   = q.en;
    assign stat_q = q.stat;
    assign irq    = q.en & q.stat;

endmodule

// File: rtl/tcq_regs.sv
module tcq_regs
    import tcq_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic                  busy,
    input  logic [N-1:0]          issued,
    input  logic [N-1:0]          compl,
    input  logic [N-1:0][DW-1:0]  resp,
    input  logic                  irq_en,
    input  logic                  irq_stat,
    output logic                  start,
    output logic                  ctrl_en,
    output logic                  ctrl_trig,
    output logic [N-1:0]          sel,
    output logic [N-1:0]          need_rsp,
    output logic [N-1:0]          slot_write,
    output logic [N-1:0][DW-1:0]  slot_adr,
    output logic [N-1:0][DW-1:0]  slot_dat
);

    typedef struct packed {
        logic [N-1:0][DW-1:0] msg;
        logic [N-1:0][DW-1:0] adr;
        logic [N-1:0][DW-1:0] dat;
        logic [N-1:0]         sel;
        logic [N-1:0]         wt;
        logic                 c_en;
        logic                 c_trig;
    } regs_t;

    regs_t q, d;
    logic  start_c;

    function automatic logic [AW-1:0] slot_off(input int idx, input int fld);
        return AW'(SLOT_BASE + idx * SLOT_STRIDE + fld);
    endfunction

    // write path
    always_comb begin
        d       = q;
        start_c = 1'b0;
        if (bus_we) begin
            if (bus_addr == AW'(OFF_CTRL)) begin
                start_c  = q.c_en & ~q.c_trig
                         & bus_wdata[CTRL_EN_BIT] & bus_wdata[CTRL_TRIG_BIT];
                d.c_en   = bus_wdata[CTRL_EN_BIT];
                d.c_trig = bus_wdata[CTRL_TRIG_BIT];
            end
            if (!busy) begin
                if (bus_addr == AW'(OFF_SEL))  d.sel = bus_wdata[N-1:0];
                if (bus_addr == AW'(OFF_WAIT)) d.wt  = bus_wdata[N-1:0];
                for (int i = 0; i < N; i++) begin
                    if (bus_addr == slot_off(i, SLOT_MSG)) d.msg[i] = bus_wdata;
                    if (bus_addr == slot_off(i, SLOT_ADR)) d.adr[i] = bus_wdata;
                    if (bus_addr == slot_off(i, SLOT_DAT)) d.dat[i] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_IRQ_EN))   bus_rdata[0] = irq_en;
        if (bus_addr == AW'(OFF_IRQ_STAT)) bus_rdata[0] = irq_stat;
        if (bus_addr == AW'(OFF_WAIT))     bus_rdata[N-1:0] = q.wt;
        if (bus_addr == AW'(OFF_SEL))      bus_rdata[N-1:0] = q.sel;
        if (bus_addr == AW'(OFF_IDLE))     bus_rdata[0] = ~busy;
        if (bus_addr == AW'(OFF_CTRL)) begin
            bus_rdata[CTRL_EN_BIT]   = q.c_en;
            bus_rdata[CTRL_TRIG_BIT] = q.c_trig;
        end
        for (int i = 0; i < N; i++) begin
            if (bus_addr == slot_off(i, SLOT_MSG)) bus_rdata = q.msg[i];
            if (bus_addr == slot_off(i, SLOT_ADR)) bus_rdata = q.adr[i];
            if (bus_addr == slot_off(i, SLOT_DAT)) bus_rdata = q.dat[i];
            if (bus_addr == slot_off(i, SLOT_RSP)) bus_rdata = resp[i];
            if (bus_addr == slot_off(i, SLOT_STS)) begin
                bus_rdata[STS_ISS_BIT] = issued[i];
                bus_rdata[STS_CMP_BIT] = compl[i];
            end
        end
    end

    // per-slot decoded attributes
    for (genvar g = 0; g < N; g++) begin : g_slot
        assign need_rsp[g]   = q.wt[g] | q.msg[g][MSG_RESP_BIT];
        assign slot_write[g] = q.msg[g][MSG_WR_BIT];
        assign slot_adr[g]   = q.adr[g];
        assign slot_dat[g]   = q.dat[g];
    end

    assign start     = start_c;
    assign ctrl_en   = q.c_en;
    assign ctrl_trig = q.c_trig;
    assign sel       = q.sel;

endmodule

// File: rtl/tcq_engine.sv
module tcq_engine
    import tcq_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  trig,
    input  logic [N-1:0]          sel,
    input  logic [N-1:0]          need_rsp,
    input  logic [N-1:0]          slot_write,
    input  logic [N-1:0][DW-1:0]  slot_adr,
    input  logic [N-1:0][DW-1:0]  slot_dat,
    input  logic                  req_ready,
    input  logic                  rsp_valid,
    input  logic [DW-1:0]         rsp_data,
    output logic                  busy,
    output logic                  done,
    output logic                  req_valid,
    output logic [DW-1:0]         req_addr,
    output logic [DW-1:0]         req_data,
    output logic                  req_write,
    output logic                  req_resp,
    output logic [N-1:0]          issued,
    output logic [N-1:0]          compl,
    output logic [N-1:0][DW-1:0]  resp
);

    localparam int            IW   = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef struct packed {
        eng_state_e           st;
        logic [IW-1:0]        ptr;
        logic [N-1:0]         iss;
        logic [N-1:0]         cmp;
        logic [N-1:0][DW-1:0] rsp;
    } eng_t;

    eng_t q, d;
    logic done_c;

    always_comb begin
        d      = q;
        done_c = 1'b0;
        case (q.st)
            ENG_IDLE: begin
                if (start) begin
                    d.st  = ENG_SCAN;
                    d.ptr = '0;
                    d.iss = '0;
                    d.cmp = '0;
                end
            end
            ENG_SCAN: begin
                if (sel[q.ptr]) begin
                    d.st = ENG_REQ;
                end else if (q.ptr == LAST) begin
                    d.st   = ENG_HOLD;
                    done_c = 1'b1;
                end else begin
                    d.ptr = q.ptr + IW'(1);
                end
            end
            ENG_REQ: begin
                if (req_ready) begin
                    d.iss[q.ptr] = 1'b1;
                    if (need_rsp[q.ptr]) begin
                        d.st = ENG_RSP;
                    end else begin
                        d.cmp[q.ptr] = 1'b1;
                        if (q.ptr == LAST) begin
                            d.st   = ENG_HOLD;
                            done_c = 1'b1;
                        end else begin
                            d.ptr = q.ptr + IW'(1);
                            d.st  = ENG_SCAN;
                        end
                    end
                end
            end
            ENG_RSP: begin
                if (rsp_valid) begin
                    d.cmp[q.ptr] = 1'b1;
                    d.rsp[q.ptr] = rsp_data;
                    if (q.ptr == LAST) begin
                        d.st   = ENG_HOLD;
                        done_c = 1'b1;
                    end else begin
                        d.ptr = q.ptr + IW'(1);
                        d.st  = ENG_SCAN;
                    end
                end
            end
            ENG_HOLD: begin
                if (!trig) begin
                    if (start) begin
                        d.st  = ENG_SCAN;
                        d.ptr = '0;
                        d.iss = '0;
                        d.cmp = '0;
                    end else begin
                        d.st = ENG_IDLE;
                    end
                end
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ENG_IDLE);
    assign done      = done_c;
    assign req_valid = (q.st == ENG_REQ);
    assign req_addr  = slot_adr[q.ptr];
    assign req_data  = slot_dat[q.ptr];
    assign req_write = slot_write[q.ptr];
    assign req_resp  = need_rsp[q.ptr];
    assign issued    = q.iss;
    assign compl     = q.cmp;
    assign resp      = q.rsp;

endmodule

// File: rtl/trig_cmd_seq.sv
module trig_cmd_seq
    import tcq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int DW        = 32,
    parameter int AW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [DW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic          req_write,
    output logic          req_resp,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          irq
);

    logic                         busy;
    logic                         done;
    logic                         start;
    logic                         ctrl_en;
    logic                         ctrl_trig;
    logic                         irq_en;
    logic                         irq_stat;
    logic [NUM_SLOTS-1:0]         cmd_sel;
    logic [NUM_SLOTS-1:0]         need_rsp;
    logic [NUM_SLOTS-1:0]         slot_write;
    logic [NUM_SLOTS-1:0]         issued;
    logic [NUM_SLOTS-1:0]         compl;
    logic [NUM_SLOTS-1:0][DW-1:0] slot_adr;
    logic [NUM_SLOTS-1:0][DW-1:0] slot_dat;
    logic [NUM_SLOTS-1:0][DW-1:0] resp;

    tcq_regs #(.N(NUM_SLOTS), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .issued     (issued),
        .compl      (compl),
        .resp       (resp),
        .irq_en     (irq_en),
        .irq_stat   (irq_stat),
        .start      (start),
        .ctrl_en    (ctrl_en),
        .ctrl_trig  (ctrl_trig),
        .sel        (cmd_sel),
        .need_rsp   (need_rsp),
        .slot_write (slot_write),
        .slot_adr   (slot_adr),
        .slot_dat   (slot_dat)
    );

    tcq_engine #(.N(NUM_SLOTS), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .trig       (ctrl_trig),
        .sel        (cmd_sel),
        .need_rsp   (need_rsp),
        .slot_write (slot_write),
        .slot_adr   (slot_adr),
        .slot_dat   (slot_dat),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .busy       (busy),
        .done       (done),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_write  (req_write),
        .req_resp   (req_resp),
        .issued     (issued),
        .compl      (compl),
        .resp       (resp)
    );

    tcq_irq #(.AW(AW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wbit     (bus_wdata[0]),
        .done     (done),
        .en_q     (irq_en),
        .stat_q   (irq_stat),
        .irq      (irq)
    );

endmodule

// File: rtl/tcq_checker.sv
module tcq_checker #(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_resp,
    input logic [DW-1:0] req_addr,
    input logic [DW-1:0] req_data,
    input logic          busy,
    input logic          done,
    input logic          ctrl_en,
    input logic          irq_stat,
    input logic [N-1:0]  cmd_sel,
    input logic [N-1:0]  issued
);

    // R3: a pending request holds its payload until accepted
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

    // R4: an accepted command that needs a response blocks the next request
    assert_rsp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_resp |=> !req_valid);

    // R2: the engine leaves idle only if the enable bit was already stored
    assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_en));

    // R9: the select mask cannot change across a busy cycle
    assert_locked_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(cmd_sel));

    // R5: done status never rises with a selected slot left unissued
    assert_done_all_issued_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> &(issued | ~cmd_sel));

    // R7: the status flag is raised only by an engine completion
    assert_stat_from_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> $past(done));

endmodule

bind trig_cmd_seq tcq_checker #(.N(NUM_SLOTS), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_resp  (req_resp),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .busy      (busy),
    .done      (done),
    .ctrl_en   (ctrl_en),
    .irq_stat  (irq_stat),
    .cmd_sel   (cmd_sel),
    .issued    (issued)
);

// File: tb/trig_cmd_seq_bench.sv
`timescale 1ns/1ps
module trig_cmd_seq_bench;

    localparam int N  = 16;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam logic [31:0] C_EN   = 32'h0001_0000;
    localparam logic [31:0] C_TRIG = 32'h0100_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [DW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          req_write;
    logic          req_resp;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;

    logic [31:0]  m_msg [N];
    logic [31:0]  m_adr [N];
    logic [31:0]  m_dat [N];
    logic [31:0]  m_rsp [N];
    logic [N-1:0] m_sel;
    logic [N-1:0] m_wt;

    always #10 clk = ~clk;

    trig_cmd_seq #(.NUM_SLOTS(N), .DW(DW), .AW(AW)) u_trig_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_write (req_write),
        .req_resp  (req_resp),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic int soff(input int i, input int f);
        return 'h30 + 20 * i + f;
    endfunction

    function automatic bit exp_need(input int i);
        return m_wt[i] | m_msg[i][8];
    endfunction

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic fill();
        for (int i = 0; i < N; i++) begin
            m_msg[i] = 32'h8 | (32'($urandom_range(0, 1)) << 8) | (32'($urandom_range(0, 1)) << 16);
            m_adr[i] = $urandom;
            m_dat[i] = $urandom;
            m_rsp[i] = $urandom;
        end
        m_wt  = N'($urandom);
        m_sel = N'($urandom);
    endtask

    task automatic run_xfer(input bit irq_on, input bit poke);
        logic [31:0] v;
        bit first = 1'b1;
        bit extra = 1'b0;
        int fs = 0;
        int tries;
        for (int i = 0; i < N; i++) begin
            wr(soff(i, 0), m_msg[i]);
            wr(soff(i, 4), m_adr[i]);
            wr(soff(i, 8), m_dat[i]);
        end
        wr('h10, 32'(m_wt));
        wr('h1C, 32'(m_sel));
        wr('h00, 32'(irq_on));
        // arming order: clear, enable, enable+trigger
        wr('h14, 32'h0);
        wr('h14, C_EN);
        wr('h14, C_EN | C_TRIG);
        for (int i = 0; i < N; i++) begin
            if (m_sel[i]) begin
                tries = 0;
                while (!req_valid && tries < 60) begin
                    @(negedge clk);
                    tries++;
                end
                chk(req_valid, "R3 request for selected slot", 32'(req_valid), 32'h1);
                if (poke && first) begin
                    fs = i;
                    wr(soff(i, 4), ~m_adr[i]);
                    wr('h1C, ~32'(m_sel));
                    wr('h10, ~32'(m_wt));
                end
                first = 1'b0;
                chk(req_addr == m_adr[i], "R3 address in slot order", req_addr, m_adr[i]);
                chk(req_data == m_dat[i], "R3 data of slot", req_data, m_dat[i]);
                chk(req_write == m_msg[i][16], "R3 write flag", 32'(req_write), 32'(m_msg[i][16]));
                chk(req_resp == exp_need(i), "R4 response flag", 32'(req_resp), 32'(exp_need(i)));
                repeat ($urandom_range(0, 2)) @(negedge clk);
                chk(req_valid && req_addr == m_adr[i], "R3 request held until accepted", req_addr, m_adr[i]);
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                if (exp_need(i)) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    chk(!req_valid, "R4 no request before response", 32'(req_valid), 32'h0);
                    rsp_valid = 1'b1;
                    rsp_data  = m_rsp[i];
                    @(negedge clk);
                    rsp_valid = 1'b0;
                end
            end
        end
        repeat (20) begin
            @(negedge clk);
            if (req_valid) extra = 1'b1;
        end
        chk(!extra, "R3 no request beyond selected slots", 32'(extra), 32'h0);
        rd('h18, v);
        chk(v == 32'h0, "R6 idle flag low until trigger cleared", v, 32'h0);
        rd('h04, v);
        chk(v == 32'h1, (m_sel == '0) ? "R10 empty set raises done" : "R7 done status set", v, 32'h1);
        chk(irq == irq_on, "R7 irq pin gated by enable", 32'(irq), 32'(irq_on));
        for (int i = 0; i < N; i++) begin
            rd(soff(i, 12), v);
            chk(v == (m_sel[i] ? 32'h0001_0100 : 32'h0), "R5 slot status word", v,
                m_sel[i] ? 32'h0001_0100 : 32'h0);
            if (m_sel[i] && exp_need(i)) begin
                rd(soff(i, 16), v);
                chk(v == m_rsp[i], "R4 response data stored", v, m_rsp[i]);
            end
        end
        if (poke) begin
            rd(soff(fs, 4), v);
            chk(v == m_adr[fs], "R9 slot write ignored while busy", v, m_adr[fs]);
            rd('h1C, v);
            chk(v == 32'(m_sel), "R9 select write ignored while busy", v, 32'(m_sel));
            rd('h10, v);
            chk(v == 32'(m_wt), "R9 wait write ignored while busy", v, 32'(m_wt));
        end
        wr('h14, C_EN);
        repeat (2) @(negedge clk);
        rd('h18, v);
        chk(v == 32'h1, "R6 idle after trigger cleared", v, 32'h1);
        wr('h08, 32'h1);
        rd('h04, v);
        chk(v == 32'h0, "R8 status cleared by write-one", v, 32'h0);
        chk(irq == 1'b0, "R8 irq pin dropped", 32'(irq), 32'h0);
        rd('h08, v);
        chk(v == 32'h0, "R8 clear offset reads zero", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        bit seen;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h18, v); chk(v == 32'h1, "R1 idle flag after reset", v, 32'h1);
        rd('h14, v); chk(v == 32'h0, "R1 control after reset", v, 32'h0);
        rd('h04, v); chk(v == 32'h0, "R1 irq status after reset", v, 32'h0);
        rd(soff(0, 4), v); chk(v == 32'h0, "R1 slot address after reset", v, 32'h0);
        chk(!req_valid && !irq, "R1 outputs low after reset", 32'({req_valid, irq}), 32'h0);

        // R2 enable and trigger together from zero must not start
        wr('h14, C_EN | C_TRIG);
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (req_valid) seen = 1'b1;
        end
        rd('h18, v);
        chk(v == 32'h1 && !seen, "R2 no start without prior enable", v, 32'h1);
        wr('h14, 32'h0);

        // directed: first and last slot only
        fill(); m_sel = 16'h8001; run_xfer(1'b1, 1'b0);
        // R10 empty selection
        fill(); m_sel = '0; run_xfer(1'b1, 1'b0);
        // R9 writes during a busy transfer
        fill(); m_sel = 16'h0020; m_wt = 16'h0020; run_xfer(1'b1, 1'b1);
        // every slot, interrupt masked
        fill(); m_sel = '1; run_xfer(1'b0, 1'b0);

        for (int k = 0; k < 10; k++) begin
            fill();
            run_xfer(k[0], 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule